// File: doc/BRIEF.md
# Banked Two-Level Indexed Register Port

This block is a byte-wide register slave that exposes only two host locations. One holds a register number and the other moves data to or from the register that number selects. The index space is divided into one bank of 8-bit registers for each card socket. The socket is picked by a single index bit, so the second bank starts 0x40 above the first. Each bank also contains its own pointer/data pair. This pair opens a second, smaller indirect space. That space holds per-socket extended registers and one register that both banks share.

A host access is a valid/ready strobe. The block takes a request in the cycle where `req_valid_i` is high and `req_ready_o` is low. It answers the next cycle with a single-cycle `req_ready_o` and, for reads, the data. Data accesses never move the index, so read-modify-write sequences can rewrite the same index safely. For every data read that decodes into a bank, a one-cycle pulse carries the socket and register number to neighbouring logic, which can use it to clear state on read.

Top module: `banked_regport`

## Requirements
- R1: After reset the index register, every bank register, both extended pointers and all extended registers read 0x00, and `req_ready_o` is low.
- R2: A request is accepted on a rising edge where `req_valid_i` is high and `req_ready_o` is low. `req_ready_o` is then high for exactly the following cycle, and `rsp_rdata_o` holds the read result during that cycle.
- R3: Address 0 reads and writes the index register. Address 1 accesses the register named by the last value written to the index. Data accesses leave the index unchanged.
- R4: Index bits [5:0] give the register number and bit 6 the socket. An index with bit 7 set, or with a register number of 0x30 or above, reads 0x00, and writes to it are ignored.
- R5: The two sockets' banks are separate storage: a write through index n never changes the value read through index n^0x40.
- R6: Adjacent registers are independent bytes, so a 16-bit value kept low byte at index n and high byte at index n+1 reads back intact.
- R7: Bank register 0x2E is that socket's extended pointer and 0x2F its extended data. Extended registers 0x00..0x0F are private to each socket.
- R8: Extended register 0x20 is one shared register, reachable from both banks. Bit s reads input `sense_i[s]` and cannot be written. Bits [7:2] are storage shared by both sockets.
- R9: An extended pointer value that selects no implemented extended register reads 0x00 through extended data, and writes there are ignored.
- R10: Each data read whose index has bit 7 clear raises `rd_pulse_o` for exactly the `req_ready_o` cycle, with `rd_sock_o` = index bit 6 and `rd_reg_o` = index bits [5:0]. Writes, index reads and reads with index bit 7 set raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request strobe, held until ready |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 1 | 0 = index register, 1 = data register |
| req_wdata_i | input | 8 | Write data |
| req_ready_o | output | 1 | One-cycle completion |
| rsp_rdata_o | output | 8 | Read data, valid with ready |
| sense_i | input | 2 | Per-socket status bits shown in the shared register |
| rd_pulse_o | output | 1 | Data-read pulse |
| rd_sock_o | output | 1 | Socket of the pulsed read |
| rd_reg_o | output | 6 | Register number of the pulsed read |

## Verification
Some properties are checked on every cycle by assertions. These cover the single-cycle completion pulse, an index that stays put across data accesses, a read pulse only on a data-read completion, zero data for out-of-range indices, and an extended pointer that moves only when written. The bench scenarios are the only evidence for the rest. That covers socket separation, independence of adjacent bytes, routing through the extended pair, the shared register seen identically from both banks with its live sense bits, and ignored writes to unimplemented locations. Each of these needs a write followed by a later read, possibly through the other socket.

// File: rtl/banked_regport_pkg.sv
package banked_regport_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned REG_W     = 6;
  localparam int unsigned NUM_SOCK  = 2;
  localparam int unsigned BANK_REGS = 48;
  localparam int unsigned EXT_REGS  = 16;
  localparam logic [REG_W-1:0]  EXT_PTR_REG = 6'h2E;
  localparam logic [REG_W-1:0]  EXT_DAT_REG = 6'h2F;
  localparam logic [DATA_W-1:0] EXT_SHARED  = 8'h20;

  typedef enum logic {HOST_INDEX = 1'b0, HOST_DATA = 1'b1} host_addr_e;
endpackage

// File: rtl/banked_regport_host.sv
module banked_regport_host
  import banked_regport_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned RW     = REG_W,
  parameter int unsigned SW     = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          we_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] bank_rdata_i,
  input  logic          idx_hit_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] index_o,
  output logic          data_wr_o,
  output logic          rd_pulse_o,
  output logic [SW-1:0] rd_sock_o,
  output logic [RW-1:0] rd_reg_o
);
  logic          ready_q, we_q, addr_q, pulse_q;
  logic [DW-1:0] index_q, rdata_q;
  logic [SW-1:0] sock_q;
  logic [RW-1:0] reg_q;
  logic          acc;

  assign acc       = valid_i && !ready_q;
  assign data_wr_o = acc && we_i && (addr_i == HOST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= 1'b0;
      pulse_q <= 1'b0;
      index_q <= '0;
      rdata_q <= '0;
      sock_q  <= '0;
      reg_q   <= '0;
    end else begin
      ready_q <= acc;
      pulse_q <= acc && !we_i && (addr_i == HOST_DATA) && idx_hit_i;
      if (acc) begin
        we_q   <= we_i;
        addr_q <= addr_i;
        sock_q <= index_q[RW +: SW];
        reg_q  <= index_q[RW-1:0];
        if (!we_i)
          rdata_q <= (addr_i == HOST_DATA) ? bank_rdata_i : index_q;
        else if (addr_i == HOST_INDEX)
          index_q <= wdata_i;
      end
    end
  end

  assign ready_o    = ready_q;
  assign rdata_o    = rdata_q;
  assign index_o    = index_q;
  assign rd_pulse_o = pulse_q;
  assign rd_sock_o  = sock_q;
  assign rd_reg_o   = reg_q;

  a_r2_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> !ready_q);
  a_r3_index_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && addr_i == HOST_DATA) |=> $stable(index_q));
  a_r10_pulse_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> (ready_q && !we_q && addr_q == HOST_DATA));
endmodule

// File: rtl/banked_regport_bank.sv
module banked_regport_bank
  import banked_regport_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned RW    = REG_W,
  parameter int unsigned NREGS = BANK_REGS,
  parameter int unsigned NEXT  = EXT_REGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [RW-1:0] reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] shared_rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          shared_wr_o
);
  localparam int unsigned EAW = $clog2(NEXT);
  localparam logic [RW-1:0] REG_LIM = RW'(NREGS);
  localparam logic [DW-1:0] EXT_LIM = DW'(NEXT);

  logic [DW-1:0] regs_q [NREGS];
  logic [DW-1:0] ext_q  [NEXT];
  logic [DW-1:0] ext_ptr_q;
  logic          is_ptr, is_dat, is_plain, ext_priv, ext_shr;
  logic [DW-1:0] ext_rd;

  assign is_ptr   = (reg_i == EXT_PTR_REG);
  assign is_dat   = (reg_i == EXT_DAT_REG);
  assign is_plain = (reg_i < REG_LIM) && !is_ptr && !is_dat;
  assign ext_priv = (ext_ptr_q < EXT_LIM);
  assign ext_shr  = (ext_ptr_q == EXT_SHARED);

  always_comb begin
    ext_rd = '0;
    if (ext_priv)     ext_rd = ext_q[ext_ptr_q[EAW-1:0]];
    else if (ext_shr) ext_rd = shared_rd_i;
  end

  always_comb begin
    rdata_o = '0;
    if (is_ptr)        rdata_o = ext_ptr_q;
    else if (is_dat)   rdata_o = ext_rd;
    else if (is_plain) rdata_o = regs_q[reg_i];
  end

  assign shared_wr_o = wr_en_i && is_dat && ext_shr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_ptr_q <= '0;
      for (int i = 0; i < int'(NREGS); i++) regs_q[i] <= '0;
      for (int j = 0; j < int'(NEXT); j++)  ext_q[j]  <= '0;
    end else if (wr_en_i) begin
      if (is_ptr)                    ext_ptr_q <= wdata_i;
      else if (is_dat && ext_priv)   ext_q[ext_ptr_q[EAW-1:0]] <= wdata_i;
      else if (is_plain)             regs_q[reg_i] <= wdata_i;
    end
  end

  a_r7_ptr_moves_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && is_ptr) |=> $stable(ext_ptr_q));
endmodule

// File: rtl/banked_regport.sv
module banked_regport
  import banked_regport_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned RW    = REG_W,
  parameter int unsigned NSOCK = NUM_SOCK,
  parameter int unsigned NREGS = BANK_REGS,
  parameter int unsigned NEXT  = EXT_REGS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic             req_ready_o,
  output logic [DW-1:0]    rsp_rdata_o,
  input  logic [NSOCK-1:0] sense_i,
  output logic             rd_pulse_o,
  output logic [$clog2(NSOCK)-1:0] rd_sock_o,
  output logic [RW-1:0]    rd_reg_o
);
  localparam int unsigned SW   = $clog2(NSOCK);
  localparam int unsigned SHRW = DW - NSOCK;

  logic [DW-1:0]   index, bank_rdata;
  logic [SW-1:0]   sock;
  logic            idx_hit, data_wr;
  logic [DW-1:0]   bank_rd  [NSOCK];
  logic [NSOCK-1:0] shr_wr;
  logic [SHRW-1:0] shared_q;
  logic [DW-1:0]   shared_rd;

  assign sock    = index[RW +: SW];
  assign idx_hit = (index[DW-1:RW+SW] == '0) && (int'(sock) < int'(NSOCK));
  assign bank_rdata = idx_hit ? bank_rd[sock] : '0;
  assign shared_rd  = {shared_q, sense_i};

  banked_regport_host #(.DW(DW), .RW(RW), .SW(SW)) u_host (
    .clk_i, .rst_ni,
    .valid_i(req_valid_i), .we_i(req_we_i), .addr_i(req_addr_i),
    .wdata_i(req_wdata_i), .bank_rdata_i(bank_rdata), .idx_hit_i(idx_hit),
    .ready_o(req_ready_o), .rdata_o(rsp_rdata_o), .index_o(index),
    .data_wr_o(data_wr), .rd_pulse_o, .rd_sock_o, .rd_reg_o
  );

  for (genvar s = 0; s < int'(NSOCK); s++) begin : g_bank
    banked_regport_bank #(.DW(DW), .RW(RW), .NREGS(NREGS), .NEXT(NEXT)) u_bank (
      .clk_i, .rst_ni,
      .wr_en_i(data_wr && idx_hit && (int'(sock) == s)),
      .reg_i(index[RW-1:0]), .wdata_i(req_wdata_i),
      .shared_rd_i(shared_rd), .rdata_o(bank_rd[s]), .shared_wr_o(shr_wr[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shared_q <= '0;
    else if (|shr_wr) shared_q <= req_wdata_i[DW-1:NSOCK];
  end

  a_r4_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o && !req_we_i && req_addr_i && index[DW-1])
    |=> (rsp_rdata_o == '0));
  a_r8_one_shared_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(shr_wr));
endmodule

// File: tb/banked_regport_test.sv
module banked_regport_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       valid = 1'b0, we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] sense = 2'b00;
  logic       ready, pulse;
  logic [7:0] rdata;
  logic [0:0] psock;
  logic [5:0] preg;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regport uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_ready_o(ready),
    .rsp_rdata_o(rdata), .sense_i(sense), .rd_pulse_o(pulse),
    .rd_sock_o(psock), .rd_reg_o(preg)
  );

  logic [7:0] l_data;
  logic       l_pulse;
  logic [0:0] l_sock;
  logic [5:0] l_reg;
  logic       l_ready_after;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic a, input logic [7:0] d);
    @(negedge clk);
    valid = 1'b1; we = w; addr = a; wdata = d;
    do @(negedge clk); while (!ready);
    l_data = rdata; l_pulse = pulse; l_sock = psock; l_reg = preg;
    valid = 1'b0;
    @(negedge clk);
    l_ready_after = ready;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    xfer(1'b1, 1'b0, idx);
    xfer(1'b1, 1'b1, d);
  endtask

  task automatic rd_reg(input logic [7:0] idx);
    xfer(1'b1, 1'b0, idx);
    xfer(1'b0, 1'b1, 8'h00);
  endtask

  task automatic t_reset;
    chk("R1 ready low", ready, 0);
    xfer(1'b0, 1'b0, 8'h00);
    chk("R1 index zero", l_data, 8'h00);
    xfer(1'b0, 1'b1, 8'h00);
    chk("R1 reg0 zero", l_data, 8'h00);
    rd_reg(8'h2E);
    chk("R1 ext ptr zero", l_data, 8'h00);
    xfer(1'b1, 1'b0, 8'h2F);
    xfer(1'b0, 1'b1, 8'h00);
    chk("R1 ext reg zero", l_data, 8'h00);
  endtask

  task automatic t_basic;
    xfer(1'b1, 1'b0, 8'h05);
    chk("R2 ready one cycle", l_ready_after, 0);
    xfer(1'b1, 1'b1, 8'hA5);
    chk("R10 no pulse on write", l_pulse, 0);
    xfer(1'b0, 1'b0, 8'h00);
    chk("R3 index readback", l_data, 8'h05);
    chk("R10 no pulse on index read", l_pulse, 0);
    xfer(1'b0, 1'b1, 8'h00);
    chk("R3 data readback", l_data, 8'hA5);
    chk("R10 pulse", l_pulse, 1);
    chk("R10 pulse sock", l_sock, 0);
    chk("R10 pulse reg", l_reg, 6'h05);
    chk("R2 ready drops", l_ready_after, 0);
    xfer(1'b0, 1'b0, 8'h00);
    chk("R3 index kept after data read", l_data, 8'h05);
  endtask

  task automatic t_sockets;
    wr_reg(8'h45, 8'h3C);
    rd_reg(8'h45);
    chk("R5 sock1 readback", l_data, 8'h3C);
    chk("R10 pulse sock1", l_sock, 1);
    chk("R10 pulse reg sock1", l_reg, 6'h05);
    rd_reg(8'h05);
    chk("R5 sock0 untouched", l_data, 8'hA5);
  endtask

  task automatic t_pair;
    wr_reg(8'h10, 8'h34);
    wr_reg(8'h11, 8'h12);
    rd_reg(8'h10);
    chk("R6 low byte", l_data, 8'h34);
    rd_reg(8'h11);
    chk("R6 high byte", l_data, 8'h12);
  endtask

  task automatic t_unmapped;
    wr_reg(8'h85, 8'hFF);
    rd_reg(8'h85);
    chk("R4 high index reads zero", l_data, 8'h00);
    chk("R10 no pulse high index", l_pulse, 0);
    rd_reg(8'h05);
    chk("R4 alias write ignored", l_data, 8'hA5);
    wr_reg(8'h30, 8'h77);
    rd_reg(8'h30);
    chk("R4 reg 0x30 reads zero", l_data, 8'h00);
    wr_reg(8'h7F, 8'h77);
    rd_reg(8'h7F);
    chk("R4 reg 0x3F sock1 reads zero", l_data, 8'h00);
  endtask

  task automatic t_ext;
    wr_reg(8'h2E, 8'h03);
    wr_reg(8'h2F, 8'h5A);
    wr_reg(8'h6E, 8'h03);
    wr_reg(8'h6F, 8'hC3);
    rd_reg(8'h2F);
    chk("R7 sock0 ext3", l_data, 8'h5A);
    rd_reg(8'h6F);
    chk("R7 sock1 ext3", l_data, 8'hC3);
    rd_reg(8'h2E);
    chk("R7 ext ptr readback", l_data, 8'h03);
    rd_reg(8'h03);
    chk("R7 bank reg3 separate", l_data, 8'h00);
  endtask

  task automatic t_shared;
    sense = 2'b01;
    wr_reg(8'h2E, 8'h20);
    wr_reg(8'h2F, 8'hFF);
    rd_reg(8'h2F);
    chk("R8 shared via sock0", l_data, 8'hFD);
    wr_reg(8'h6E, 8'h20);
    rd_reg(8'h6F);
    chk("R8 shared via sock1", l_data, 8'hFD);
    sense = 2'b10;
    rd_reg(8'h6F);
    chk("R8 live sense", l_data, 8'hFE);
    wr_reg(8'h6F, 8'h08);
    rd_reg(8'h2F);
    chk("R8 sock1 write seen by sock0", l_data, 8'h0A);
  endtask

  task automatic t_ext_unmapped;
    wr_reg(8'h2E, 8'h40);
    wr_reg(8'h2F, 8'h99);
    rd_reg(8'h2F);
    chk("R9 ext 0x40 reads zero", l_data, 8'h00);
    wr_reg(8'h2E, 8'h10);
    rd_reg(8'h2F);
    chk("R9 ext 0x10 reads zero", l_data, 8'h00);
    wr_reg(8'h2E, 8'h03);
    rd_reg(8'h2F);
    chk("R9 ext3 untouched", l_data, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sockets();
    t_pair();
    t_unmapped();
    t_ext();
    t_shared();
    t_ext_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule